// File: doc/BRIEF.md
# Configuration Load Sequencer

This block sequences the loading of a configuration image into a small programmable device over a serial peripheral link. It filters an active-low configuration-restart input and accepts only pulses that stay low for a minimum width. A qualifying pulse takes effect on its rising edge and starts a memory-clear wait. After the wait the block hunts for a 32-bit synchronization word in the serial stream. It then shifts in a fixed number of configuration bits, sampled on rising serial-clock edges, and presents them as words.

When the last bit has been stored, the block raises a done flag. It keeps user I/O disabled for a fixed number of system clocks, then enables the I/O and stops the internal configuration oscillator. An oscillator speed field in the first configuration word selects the oscillator mode used during the load.

All intervals are counted in system-clock cycles. The serial clock, the serial data and the restart input each pass through a two-flop synchronizer.

Top module: `cfg_load_seq`

## Requirements
- R1: After rst_ni is released, done_o, io_en_o and cfg_vld_o are 0, osc_en_o is 1 and osc_mode_o is 2'b00 (default).
- R2: A low pulse on cfg_rst_ni that lasts fewer than RST_MIN_CYC clock cycles has no effect: done_o, io_en_o and osc_en_o keep their values.
- R3: A low pulse on cfg_rst_ni that lasts at least RST_MIN_CYC cycles aborts any load when cfg_rst_ni rises. It clears done_o, io_en_o and cfg_vld_o, sets osc_en_o to 1 and osc_mode_o to default, and starts the clear wait.
- R4: For CLR_CYC cycles after a restart, serial-clock edges are ignored. Neither the sync hunt nor the stream sees them.
- R5: sdi_i is sampled on each rising edge of sck_i. The sync word is found when the 32 most recent samples equal SYNC_WORD, with the earliest sample as the MSB. Bits received before the sync word only feed the hunt.
- R6: After the sync word, STREAM_BITS bits are taken, MSB first, in words of WORD_W bits. Each completed word appears on cfg_word_o, with cfg_vld_o high for exactly one cycle.
- R7: done_o rises one clock cycle after the cycle in which the final word is presented on cfg_vld_o. It stays high until a restart.
- R8: io_en_o rises exactly IO_DELAY clock cycles after done_o rises, and is never high while done_o is low.
- R9: osc_en_o falls in the same cycle that io_en_o rises.
- R10: Bits [1:0] of the first stream word set osc_mode_o as follows: 01 gives low (2'b01), 10 gives high (2'b10), and 00 or 11 give default (2'b00). Before the first word arrives the mode is default.
- R11: When a qualifying restart and a serial rising edge arrive in the same cycle, the restart wins and the bit is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| cfg_rst_ni | input | 1 | Active-low configuration restart request |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| done_o | output | 1 | Configuration stream complete |
| io_en_o | output | 1 | User I/O enable |
| osc_en_o | output | 1 | Configuration oscillator running |
| osc_mode_o | output | 2 | Oscillator speed: 00 default, 01 low, 10 high |
| cfg_word_o | output | WORD_W | Last completed configuration word |
| cfg_vld_o | output | 1 | One-cycle strobe for cfg_word_o |

## Verification
The final stream bit and a qualifying restart can land in the same system cycle. The bench provokes this by driving the rising edge of cfg_rst_ni and the final rising edge of sck_i at the same clock edge. Both signals pass through synchronizers of equal depth, so they reach the control logic together. The collision is judged correct when the final word is never presented, done_o stays low, osc_mode_o drops back to default, and a later complete load after the clear wait succeeds.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_HUNT,
    ST_LOAD,
    ST_FIN,
    ST_HOLD,
    ST_RUN
  } load_state_e;

  typedef enum logic [1:0] {
    OSC_DEF  = 2'b00,
    OSC_LOW  = 2'b01,
    OSC_HIGH = 2'b10
  } osc_mode_e;

  function automatic osc_mode_e decode_mode(input logic [1:0] fld);
    case (fld)
      2'b01:   decode_mode = OSC_LOW;
      2'b10:   decode_mode = OSC_HIGH;
      default: decode_mode = OSC_DEF;
    endcase
  endfunction

endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
  parameter int           W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= INIT;
      q_o  <= INIT;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end

endmodule

// File: rtl/cfg_rst_filter.sv
module cfg_rst_filter #(
  parameter int MIN_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic restart_o
);

  localparam int CW = $clog2(MIN_CYC + 1);

  logic          lvl_q;
  logic [CW-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b1;
      low_q <= '0;
    end else begin
      lvl_q <= lvl_i;
      if (lvl_i)                      low_q <= '0;
      else if (low_q != CW'(MIN_CYC)) low_q <= low_q + 1'b1;
    end
  end

  // restart only on the rising edge of a wide enough low pulse
  assign restart_o = lvl_i & ~lvl_q & (low_q == CW'(MIN_CYC));

  // R3
  single_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);

endmodule

// File: rtl/cfg_shift_unit.sv
module cfg_shift_unit #(
  parameter int          SYNC_W      = 32,
  parameter logic [31:0] SYNC_WORD   = 32'h7EAA_997E,
  parameter int          WORD_W      = 16,
  parameter int          STREAM_BITS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              hunt_i,
  input  logic              load_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  output logic              sync_hit_o,
  output logic              last_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              first_o
);

  localparam int PW = $clog2(WORD_W);
  localparam int BW = $clog2(STREAM_BITS);

  logic [SYNC_W-2:0] hunt_q;
  logic [WORD_W-2:0] acc_q;
  logic [PW-1:0]     pos_q;
  logic [BW-1:0]     cnt_q;
  logic              first_pend_q;

  logic [SYNC_W-1:0] hunt_nxt;
  logic [WORD_W-1:0] acc_nxt;
  logic              take, word_end;

  assign hunt_nxt   = {hunt_q, bit_i};
  assign acc_nxt    = {acc_q, bit_i};
  assign sync_hit_o = hunt_i & bit_vld_i & (hunt_nxt == SYNC_WORD[SYNC_W-1:0]);
  assign take       = load_i & bit_vld_i;
  assign word_end   = take & (pos_q == PW'(WORD_W - 1));
  assign last_o     = take & (cnt_q == BW'(STREAM_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hunt_q       <= '0;
      acc_q        <= '0;
      pos_q        <= '0;
      cnt_q        <= '0;
      first_pend_q <= 1'b1;
      word_o       <= '0;
      word_vld_o   <= 1'b0;
      first_o      <= 1'b0;
    end else if (clr_i) begin
      hunt_q       <= '0;
      acc_q        <= '0;
      pos_q        <= '0;
      cnt_q        <= '0;
      first_pend_q <= 1'b1;
      word_o       <= '0;
      word_vld_o   <= 1'b0;
      first_o      <= 1'b0;
    end else begin
      word_vld_o <= word_end;
      first_o    <= word_end & first_pend_q;
      if (hunt_i && bit_vld_i) hunt_q <= hunt_nxt[SYNC_W-2:0];
      if (sync_hit_o) begin
        pos_q        <= '0;
        cnt_q        <= '0;
        first_pend_q <= 1'b1;
      end
      if (take) begin
        acc_q <= acc_nxt[WORD_W-2:0];
        cnt_q <= cnt_q + 1'b1;
        pos_q <= word_end ? '0 : pos_q + 1'b1;
        if (word_end) begin
          word_o       <= acc_nxt;
          first_pend_q <= 1'b0;
        end
      end
    end
  end

  // R6
  vld_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);

  // R10
  first_has_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |-> word_vld_o);

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfg_load_pkg::*;
#(
  parameter int          RST_MIN_CYC = 50,
  parameter int          CLR_CYC     = 75000,
  parameter int          SYNC_W      = 32,
  parameter logic [31:0] SYNC_WORD   = 32'h7EAA_997E,
  parameter int          WORD_W      = 16,
  parameter int          STREAM_BITS = 64,
  parameter int          IO_DELAY    = 49
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_rst_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              done_o,
  output logic              io_en_o,
  output logic              osc_en_o,
  output logic [1:0]        osc_mode_o,
  output logic [WORD_W-1:0] cfg_word_o,
  output logic              cfg_vld_o
);

  localparam int CLR_W = $clog2(CLR_CYC + 1);
  localparam int IO_W  = $clog2(IO_DELAY + 1);

  load_state_e      state_q;
  osc_mode_e        mode_q;
  logic [CLR_W-1:0] clr_q;
  logic [IO_W-1:0]  io_q;
  logic [2:0]       sync_s;
  logic             sck_q;
  logic             sck_rise, restart, bit_vld;
  logic             sync_hit, last_bit, first_word;

  cfg_sync2 #(.W(3), .INIT(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cfg_rst_ni, sck_i, sdi_i}),
    .q_o   (sync_s)
  );

  cfg_rst_filter #(.MIN_CYC(RST_MIN_CYC)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (sync_s[2]),
    .restart_o(restart)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sync_s[1];
  end

  assign sck_rise = sync_s[1] & ~sck_q;
  // restart beats a coincident serial edge
  assign bit_vld  = sck_rise & ~restart;

  cfg_shift_unit #(
    .SYNC_W     (SYNC_W),
    .SYNC_WORD  (SYNC_WORD),
    .WORD_W     (WORD_W),
    .STREAM_BITS(STREAM_BITS)
  ) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (restart),
    .hunt_i    (state_q == ST_HUNT),
    .load_i    (state_q == ST_LOAD),
    .bit_vld_i (bit_vld),
    .bit_i     (sync_s[0]),
    .sync_hit_o(sync_hit),
    .last_o    (last_bit),
    .word_o    (cfg_word_o),
    .word_vld_o(cfg_vld_o),
    .first_o   (first_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CLEAR;
      mode_q  <= OSC_DEF;
      clr_q   <= '0;
      io_q    <= '0;
    end else if (restart) begin
      state_q <= ST_CLEAR;
      mode_q  <= OSC_DEF;
      clr_q   <= '0;
      io_q    <= '0;
    end else begin
      if (first_word) mode_q <= decode_mode(cfg_word_o[1:0]);
      case (state_q)
        ST_CLEAR: begin
          if (clr_q == CLR_W'(CLR_CYC - 1)) state_q <= ST_HUNT;
          else                             clr_q   <= clr_q + 1'b1;
        end
        ST_HUNT:  if (sync_hit) state_q <= ST_LOAD;
        ST_LOAD:  if (last_bit) state_q <= ST_FIN;
        ST_FIN:   state_q <= ST_HOLD;
        ST_HOLD: begin
          if (io_q == IO_W'(IO_DELAY - 1)) state_q <= ST_RUN;
          else                             io_q    <= io_q + 1'b1;
        end
        ST_RUN:   state_q <= ST_RUN;
        default:  state_q <= ST_CLEAR;
      endcase
    end
  end

  assign done_o     = (state_q == ST_HOLD) || (state_q == ST_RUN);
  assign io_en_o    = (state_q == ST_RUN);
  assign osc_en_o   = (state_q != ST_RUN);
  assign osc_mode_o = mode_q;

  // R3
  restart_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !done_o && !io_en_o);

  // R4
  clear_no_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLEAR) |-> !cfg_vld_o);

  // R5
  edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_rise |=> !sck_rise);

  // R7
  done_after_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(cfg_vld_o));

  // R8
  io_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_en_o |-> done_o);

  // R8
  io_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_en_o) |-> $past(done_o));

endmodule

// File: tb/tb_cfg_load_seq.sv
module tb_cfg_load_seq;

  localparam int          RMIN  = 8;
  localparam int          CLR   = 300;
  localparam logic [31:0] SYNCW = 32'h7EAA_997E;
  localparam int          IOD   = 49;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_rst_ni = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic done_o, io_en_o, osc_en_o, cfg_vld_o;
  logic [1:0]  osc_mode_o;
  logic [15:0] cfg_word_o;

  int checks = 0, fails = 0;
  int cyc = 0, nw = 0, vld_cyc = 0, done_cyc = 0, io_cyc = 0;
  logic [15:0] words [0:7];
  logic osc_at_io = 1'b1, done_p = 1'b0, io_p = 1'b0;
  bit finished = 0;

  always #2 clk = ~clk;

  cfg_load_seq #(
    .RST_MIN_CYC(RMIN), .CLR_CYC(CLR), .SYNC_W(32), .SYNC_WORD(SYNCW),
    .WORD_W(16), .STREAM_BITS(32), .IO_DELAY(IOD)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_rst_ni(cfg_rst_ni), .sck_i(sck), .sdi_i(sdi),
    .done_o(done_o), .io_en_o(io_en_o), .osc_en_o(osc_en_o), .osc_mode_o(osc_mode_o),
    .cfg_word_o(cfg_word_o), .cfg_vld_o(cfg_vld_o)
  );

  always @(negedge clk) begin
    cyc++;
    if (cfg_vld_o) begin
      words[nw % 8] = cfg_word_o;
      nw++;
      vld_cyc = cyc;
    end
    if (done_o && !done_p) done_cyc = cyc;
    if (io_en_o && !io_p) begin
      io_cyc = cyc;
      osc_at_io = osc_en_o;
    end
    done_p = done_o;
    io_p   = io_en_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b; sck = 1'b0; tick(2);
    sck = 1'b1; tick(2);
    sck = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_rst(input int n);
    cfg_rst_ni = 1'b0; tick(n); cfg_rst_ni = 1'b1;
  endtask

  task automatic load(input logic [15:0] w0, input logic [15:0] w1);
    pulse_rst(10);
    tick(CLR + 10);
    send_bits(32'hA5, 8);
    send_bits(SYNCW, 32);
    send_bits({16'h0, w0}, 16);
    send_bits({16'h0, w1}, 16);
    tick(70);
  endtask

  task automatic t_reset;
    tick(3);
    check(done_o == 0, "R1 done", done_o, 0);
    check(io_en_o == 0, "R1 io_en", io_en_o, 0);
    check(osc_en_o == 1 && cfg_vld_o == 0, "R1 osc_en/vld", osc_en_o, 1);
    check(osc_mode_o == 2'b00, "R1 mode", osc_mode_o, 0);
  endtask

  task automatic t_full_load;
    int nw0;
    nw0 = nw;
    load(16'h5A01, 16'hC3F0);
    check(nw - nw0 == 2, "R6 word count", nw - nw0, 2);
    check(words[nw0 % 8] == 16'h5A01, "R6 word0", words[nw0 % 8], 16'h5A01);
    check(words[(nw0 + 1) % 8] == 16'hC3F0, "R6 word1", words[(nw0 + 1) % 8], 16'hC3F0);
    check(done_cyc - vld_cyc == 1, "R7 done delay", done_cyc - vld_cyc, 1);
    check(io_cyc - done_cyc == IOD, "R8 io delay", io_cyc - done_cyc, IOD);
    check(osc_at_io == 0 && osc_en_o == 0, "R9 osc off", osc_at_io, 0);
    check(osc_mode_o == 2'b01, "R10 low mode", osc_mode_o, 1);
    check(done_o == 1 && io_en_o == 1, "R7 done held", done_o, 1);
  endtask

  task automatic t_pulses;
    pulse_rst(RMIN - 1);
    tick(12);
    check(done_o == 1, "R2 done kept", done_o, 1);
    check(io_en_o == 1 && osc_en_o == 0, "R2 io kept", io_en_o, 1);
    pulse_rst(RMIN);
    tick(6);
    check(done_o == 0, "R3 done cleared", done_o, 0);
    check(io_en_o == 0 && osc_en_o == 1, "R3 io off osc on", io_en_o, 0);
    check(osc_mode_o == 2'b00, "R3 mode default", osc_mode_o, 0);
  endtask

  task automatic t_clear_ignore;
    int nw0;
    nw0 = nw;
    pulse_rst(10);
    tick(4);
    send_bits(SYNCW, 32);
    tick(CLR);
    send_bits(32'h1234_5678, 32);
    tick(80);
    check(done_o == 0, "R4 sync in clear ignored", done_o, 0);
    check(nw == nw0, "R4 no words", nw - nw0, 0);
    send_bits(SYNCW >> 16, 16);
    send_bits(SYNCW, 32);
    send_bits(32'h0002_BEEF, 32);
    tick(70);
    check(done_o == 1, "R5 sync after partial", done_o, 1);
    check(words[(nw - 1) % 8] == 16'hBEEF, "R6 last word", words[(nw - 1) % 8], 16'hBEEF);
    check(osc_mode_o == 2'b10, "R10 high mode", osc_mode_o, 2);
  endtask

  task automatic t_mode3;
    load(16'h0003, 16'h1111);
    check(done_o == 1, "R7 load done", done_o, 1);
    check(osc_mode_o == 2'b00, "R10 code 11 default", osc_mode_o, 0);
  endtask

  task automatic t_collision;
    int nw0;
    pulse_rst(10);
    tick(CLR + 10);
    send_bits(32'hA5, 8);
    send_bits(SYNCW, 32);
    send_bits(32'h0001, 16);
    send_bits(32'(16'hABCD >> 1), 15);
    tick(20);
    nw0 = nw;
    sdi = 1'b1; sck = 1'b0; cfg_rst_ni = 1'b0;
    tick(10);
    sck = 1'b1; cfg_rst_ni = 1'b1;
    tick(2);
    sck = 1'b0;
    tick(80);
    check(done_o == 0, "R11 done suppressed", done_o, 0);
    check(nw == nw0, "R11 final word dropped", nw - nw0, 0);
    check(osc_mode_o == 2'b00 && osc_en_o == 1, "R11 mode reset", osc_mode_o, 0);
    tick(CLR);
    send_bits(SYNCW, 32);
    send_bits(32'h0001_2222, 32);
    tick(70);
    check(done_o == 1 && io_en_o == 1, "R11 reload ok", done_o, 1);
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    t_reset();
    t_full_load();
    t_pulses();
    t_clear_ignore();
    t_mode3();
    t_collision();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule